// File: doc/BRIEF.md
# Output-Compare Timer with Rollover Flag

This block is a free-running up-counter with a single compare channel, controlled through a small word-addressed register port. The counter advances on a divided count clock. The division ratio comes from a prescaler register, and counting happens only while the run bit is set. Two sticky events are recorded in a status register. One marks the counter arriving at the compare value. The other marks the counter wrapping from all-ones back to zero. Software clears each event by writing a one to its bit.

A single registered interrupt line is raised when the timer is running and at least one recorded event has its matching enable bit set. The enable bits sit at the same positions as the status bits. The control register also selects how the counter behaves at a compare match. In restart mode the counter reloads to zero; in free-run mode it keeps climbing to all-ones. A control bit decides whether turning the timer on clears the counter, and a self-clearing soft-reset bit returns most of the state to zero. Several further control fields are stored and read back but have no effect on behaviour.

Top module: `ocmp_timer`

## Requirements
- R1: After the synchronous reset, every register reads zero and `irq` is low.
- R2: Register word offsets are control=0, divider=1, flags=2, interrupt-enable=3, compare=4 and counter=9. The counter is read-only. Reads of any other offset return zero, and writes to other offsets and to offset 9 change nothing.
- R3: The counter (CNT_W bits, read zero-extended) advances by one once every (divider[11:0]+1) cycles with `tick_en` high. It advances only while control bit 0 (run) is set, and it holds its value while run is clear. The divider phase restarts whenever run is clear.
- R4: A control write that takes run from 0 to 1 with control bit 1 set clears the counter. The same write with bit 1 clear leaves the counter unchanged.
- R5: When a count step lands the counter on the compare value, flags bit 0 is set. A compare write takes effect for the very next step.
- R6: With control bit 9 clear (restart), a count step taken while the counter equals the compare value loads zero. With bit 9 set (free-run), the counter simply increments.
- R7: A count step taken while the counter is all-ones wraps the counter to zero and sets flags bit 5.
- R8: Writing 1 to flags bit 0 or bit 5 clears that bit, and writing 0 leaves it unchanged. A flag being set in the same cycle as its clear wins.
- R9: `irq` is a register. It becomes high one cycle after run is set and a flag is set together with the enable bit at the same position (bit 0 or bit 5). Otherwise it is low.
- R10: Writing control with bit 15 set clears the flags, divider, interrupt-enable, compare value and counter. It stores the written control value with bits 0, 2, 3, 4 and 15 forced to zero. Control bit 15 always reads 0.
- R11: Control bits 31:16, 14:10, 8:2 (except as stated in R10) are stored and read back unchanged. They have no effect on counting, flags or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-clock enable before the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Registered level interrupt |

## Verification
A wrong counter or prescaler phase shows up at offset 9 on the first cycle after the faulty step. A compare or wrap event that is missed or spurious shows up in the flags word one cycle after the step that should have caused it, and in `irq` one cycle after that. A bad soft-reset subset is visible in the readback of every register on the cycle after the write. A reference model runs in step with the design and compares the read word and `irq` on every cycle. It uses a narrow counter width, so wraps happen within a few thousand cycles.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int PRE_W  = 12;

    localparam int FLAG_CMP_BIT = 0;
    localparam int FLAG_ROV_BIT = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 4'd0,
        REG_DIV   = 4'd1,
        REG_FLAGS = 4'd2,
        REG_IEN   = 4'd3,
        REG_CMP   = 4'd4,
        REG_COUNT = 4'd9
    } reg_sel_e;

    // Control word layout, most significant field first.
    typedef struct packed {
        logic [2:0] force_out;
        logic [2:0] oc_mode3;
        logic [2:0] oc_mode2;
        logic [2:0] oc_mode1;
        logic [1:0] ic_mode2;
        logic [1:0] ic_mode1;
        logic       soft_rst;
        logic [4:0] spare;
        logic       run_free;
        logic [2:0] clk_sel;
        logic       stop_en;
        logic       doze_en;
        logic       wait_en;
        logic       dbg_en;
        logic       clr_on_run;
        logic       run;
    } ctrl_t;

    // Value stored in control for a given write word.
    function automatic ctrl_t ctrl_on_write(input logic [DATA_W-1:0] wd);
        ctrl_t c;
        c = ctrl_t'(wd);
        c.soft_rst = 1'b0;
        if (wd[15]) begin
            c.run     = 1'b0;
            c.dbg_en  = 1'b0;
            c.wait_en = 1'b0;
            c.doze_en = 1'b0;
        end
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] flags_word(input logic cf, input logic rf);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FLAG_CMP_BIT] = cf;
        w[FLAG_ROV_BIT] = rf;
        return w;
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] div_q,
    output logic [DATA_W-1:0] ien_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              swr,
    output logic              cnt_clr,
    output logic              clr_cmp_flag,
    output logic              clr_rov_flag
);

    logic wr_ctrl, wr_div, wr_flags, wr_ien, wr_cmp;

    always_comb begin
        wr_ctrl  = wr_en && (addr == REG_CTRL);
        wr_div   = wr_en && (addr == REG_DIV);
        wr_flags = wr_en && (addr == REG_FLAGS);
        wr_ien   = wr_en && (addr == REG_IEN);
        wr_cmp   = wr_en && (addr == REG_CMP);
    end

    assign swr          = wr_ctrl && wdata[15];
    assign cnt_clr      = swr || (wr_ctrl && !ctrl_q.run && wdata[0] && wdata[1]);
    assign clr_cmp_flag = wr_flags && wdata[FLAG_CMP_BIT];
    assign clr_rov_flag = wr_flags && wdata[FLAG_ROV_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            ien_q  <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_on_write(wdata);
            if (swr) begin
                div_q <= '0;
                ien_q <= '0;
                cmp_q <= '0;
            end else begin
                if (wr_div) div_q <= wdata;
                if (wr_ien) ien_q <= wdata;
                if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ocmp_prescaler.sv
module ocmp_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             tick_en,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q == div);
    assign tick   = run && tick_en && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            phase_q <= '0;
        end else if (tick_en) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cmp_set,
    output logic             rov_set
);

    logic             reload;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        reload  = restart && (cnt_q == cmp);
        cnt_nxt = reload ? '0 : cnt_q + 1'b1;
    end

    assign cmp_set = tick && !clr && (cnt_nxt == cmp);
    assign rov_set = tick && !clr && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ocmp_status.sv
module ocmp_status (
    input  logic clk,
    input  logic rst,
    input  logic swr,
    input  logic set_cmp,
    input  logic set_rov,
    input  logic clr_cmp,
    input  logic clr_rov,
    input  logic run,
    input  logic ie_cmp,
    input  logic ie_rov,
    output logic cf_q,
    output logic rf_q,
    output logic irq_q
);

    logic irq_d;

    assign irq_d = run && ((cf_q && ie_cmp) || (rf_q && ie_rov));

    always_ff @(posedge clk) begin
        if (rst || swr) begin
            cf_q <= 1'b0;
            rf_q <= 1'b0;
        end else begin
            if (set_cmp)      cf_q <= 1'b1;
            else if (clr_cmp) cf_q <= 1'b0;
            if (set_rov)      rf_q <= 1'b1;
            else if (clr_rov) rf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] div_q, ien_q;
    logic [CNT_W-1:0]  cmp_q, cnt_q;
    logic              swr, cnt_clr, clr_cmp_flag, clr_rov_flag;
    logic              tick, cmp_set, rov_set, cf_q, rf_q;
    logic              run, restart;

    assign run     = ctrl_q.run;
    assign restart = !ctrl_q.run_free;

    ocmp_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl_q(ctrl_q), .div_q(div_q), .ien_q(ien_q), .cmp_q(cmp_q),
        .swr(swr), .cnt_clr(cnt_clr),
        .clr_cmp_flag(clr_cmp_flag), .clr_rov_flag(clr_rov_flag)
    );

    ocmp_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk(clk), .rst(rst), .clr(swr), .run(run), .tick_en(tick_en),
        .div(div_q[PRE_W-1:0]), .tick(tick)
    );

    ocmp_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .clr(cnt_clr), .tick(tick), .restart(restart),
        .cmp(cmp_q), .cnt_q(cnt_q), .cmp_set(cmp_set), .rov_set(rov_set)
    );

    ocmp_status stat_i (
        .clk(clk), .rst(rst), .swr(swr),
        .set_cmp(cmp_set), .set_rov(rov_set),
        .clr_cmp(clr_cmp_flag), .clr_rov(clr_rov_flag),
        .run(run), .ie_cmp(ien_q[FLAG_CMP_BIT]), .ie_rov(ien_q[FLAG_ROV_BIT]),
        .cf_q(cf_q), .rf_q(rf_q), .irq_q(irq)
    );

    always_comb begin
        case (addr)
            REG_CTRL:  rdata = DATA_W'(ctrl_q);
            REG_DIV:   rdata = div_q;
            REG_FLAGS: rdata = flags_word(cf_q, rf_q);
            REG_IEN:   rdata = ien_q;
            REG_CMP:   rdata = DATA_W'(cmp_q);
            REG_COUNT: rdata = DATA_W'(cnt_q);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cnt_clr,
    input logic             swr,
    input logic             run,
    input logic             restart,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             cf,
    input logic             rf,
    input logic             ie_cmp,
    input logic             ie_rov,
    input logic             irq
);

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(run && ((cf && ie_cmp) || (rf && ie_rov)))); // R9

    AST_IRQ_RAISES: assert property (@(posedge clk) disable iff (rst)
        (run && ((cf && ie_cmp) || (rf && ie_rov))) |=> irq); // R9

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_clr) |=> $stable(cnt)); // R3

    AST_CNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_clr && !(restart && cnt == cmp)) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R3

    AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_clr && restart && cnt == cmp) |=> (cnt == '0)); // R6

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_clr && (&cnt)) |=> rf); // R7

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_clr && !restart && (CNT_W'(cnt + 1'b1) == cmp)) |=> cf); // R5

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        swr |=> (cnt == '0 && !cf && !rf && !run)); // R10

endmodule

bind ocmp_timer ocmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt_clr(cnt_clr), .swr(swr),
    .run(run), .restart(restart), .cnt(cnt_q), .cmp(cmp_q),
    .cf(cf_q), .rf(rf_q), .ie_cmp(ien_q[0]), .ie_rov(ien_q[5]), .irq(irq)
);

// File: tb/ocmp_timer_tb_top.sv
`timescale 1ns/1ps
module ocmp_timer_tb_top;

    localparam int CW = 12;
    localparam logic [31:0] CMASK = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd9;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ocmp_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_ctrl, m_div, m_ien, m_cmp, m_cnt, m_phase;
    logic        m_cf, m_rf, m_irq;
    bit          armed = 0;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_ctrl;
            4'd1: return m_div;
            4'd2: return {26'd0, m_rf, 4'd0, m_cf};
            4'd3: return m_ien;
            4'd4: return m_cmp;
            4'd9: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R10/R11 ctrl";
            4'd1: return "R3/R10 divider";
            4'd2: return "R5/R7/R8 flags";
            4'd3: return "R9 ien";
            4'd4: return "R5 compare";
            4'd9: return "R3/R4/R6 counter";
            default: return "R2 unmapped";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_div = 0; m_ien = 0; m_cmp = 0; m_cnt = 0; m_phase = 0;
            m_cf = 0; m_rf = 0; m_irq = 0;
            armed = 1;
        end else if (armed) begin
            logic        run, tick, clr, swr, cset, rset, nirq;
            logic [31:0] div, ncnt, nc;
            chk(tag_of(addr), rdata, m_read(addr));
            chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
            run  = m_ctrl[0];
            div  = m_div & 32'hFFF;
            tick = run && tick_en && (m_phase == div);
            swr  = wr_en && addr == 4'd0 && wdata[15];
            clr  = swr || (wr_en && addr == 4'd0 && !run && wdata[0] && wdata[1]);
            ncnt = m_cnt;
            if (tick) ncnt = (!m_ctrl[9] && m_cnt == m_cmp) ? 32'd0 : ((m_cnt + 1) & CMASK);
            cset = tick && !clr && (ncnt == m_cmp);
            rset = tick && !clr && (m_cnt == CMASK);
            nirq = run && ((m_cf && m_ien[0]) || (m_rf && m_ien[5]));
            if (clr) ncnt = 0;
            if (swr || !run) m_phase = 0;
            else if (tick_en) m_phase = (m_phase == div) ? 32'd0 : ((m_phase + 1) & 32'hFFF);
            if (swr) begin m_cf = 0; m_rf = 0; end
            else begin
                if (cset) m_cf = 1; else if (wr_en && addr == 4'd2 && wdata[0]) m_cf = 0;
                if (rset) m_rf = 1; else if (wr_en && addr == 4'd2 && wdata[5]) m_rf = 0;
            end
            if (wr_en && addr == 4'd0) begin
                nc = wdata & ~32'h0000_8000;
                if (wdata[15]) nc = nc & ~32'h0000_001D;
                m_ctrl = nc;
            end
            if (swr) begin m_div = 0; m_ien = 0; m_cmp = 0; end
            else if (wr_en) begin
                if (addr == 4'd1) m_div = wdata;
                if (addr == 4'd3) m_ien = wdata;
                if (addr == 4'd4) m_cmp = wdata & CMASK;
            end
            m_cnt = ncnt;
            m_irq = nirq;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 4'd9;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    task automatic idle(input int n, input bit rnd);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            addr = 4'(i % 10);
            if (rnd) tick_en = 1'($urandom_range(0, 1));
        end
        addr = 4'd9;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog expired (R1 run incomplete)");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(4'd0, 0, "R1 ctrl");  rd(4'd1, 0, "R1 divider"); rd(4'd2, 0, "R1 flags");
        rd(4'd3, 0, "R1 ien");   rd(4'd4, 0, "R1 compare"); rd(4'd9, 0, "R1 counter");
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2: unmapped and read-only offsets
        wr(4'd6, 32'hDEAD_BEEF);  rd(4'd6, 0, "R2 unmapped read");
        wr(4'd9, 32'h0000_0123);  rd(4'd9, 0, "R2 counter write ignored");

        // R5/R9: free-run, compare at 20
        tick_en = 1'b1;
        wr(4'd1, 0); wr(4'd4, 20); wr(4'd3, 32'h21);
        wr(4'd0, 32'h0000_0201);
        idle(40, 0);
        rd(4'd2, 32'h1, "R5 compare flag set");
        chk("R9 irq high", {31'd0, irq}, 32'd1);

        // R8: write-one-to-clear
        wr(4'd2, 32'h20); rd(4'd2, 32'h1, "R8 zero write keeps flag");
        wr(4'd2, 32'h01); rd(4'd2, 32'h0, "R8 one write clears flag");

        // R6/R7: restart mode, wrap then bounded count
        wr(4'd0, 32'h0000_0001);
        idle(4200, 0);
        rd(4'd2, 32'h21, "R7 rollover flag set");
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1 addr = 4'd9;
            @(negedge clk);
            chk("R6 counter bounded by compare", {31'd0, rdata <= 32'd20}, 32'd1);
        end

        // R4/R3: enable mode, prescaler
        wr(4'd0, 0); idle(5, 0);
        wr(4'd1, 3);
        wr(4'd0, 32'h0000_0003);
        rd(4'd9, 0, "R4 cleared on enable");
        idle(30, 0);
        wr(4'd0, 0);
        @(posedge clk); #1 addr = 4'd9; @(negedge clk); held = rdata;
        wr(4'd0, 32'h0000_0001);
        rd(4'd9, held, "R4 kept on plain enable");
        idle(200, 1);

        // R8: clear collisions with sets, compare changes while running
        tick_en = 1'b1;
        wr(4'd1, 0); wr(4'd4, 5);
        for (int k = 0; k < 14; k++) begin
            wr(4'd2, 32'h21);
            idle(5, 0);
        end
        wr(4'd4, 9); idle(30, 0);

        // R10: soft reset
        wr(4'd1, 7); wr(4'd3, 32'hFF);
        wr(4'd0, 32'hE000_821F);
        rd(4'd0, 32'hE000_0202, "R10 ctrl after soft reset");
        rd(4'd1, 0, "R10 divider"); rd(4'd3, 0, "R10 ien"); rd(4'd4, 0, "R10 compare");
        rd(4'd2, 0, "R10 flags"); rd(4'd9, 0, "R10 counter");
        chk("R10 irq low", {31'd0, irq}, 32'd0);
        idle(20, 0);
        rd(4'd9, 0, "R3 holds while stopped");

        // R11: unused control fields stored, counting unaffected
        wr(4'd0, 32'h1FF5_7DC1);
        rd(4'd0, 32'h1FF5_7DC1, "R11 ctrl readback");
        idle(60, 1);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule